// File: doc/BRIEF.md
# Iterative 64-bit Feistel Block Cipher Core

This core encrypts or decrypts a single 64-bit block with a 256-bit key. It uses the 32-round Feistel cipher of the Soviet-era block cipher standard. Each clock runs one round. Software first loads the key with a one-cycle strobe. Each block then starts with a one-cycle start strobe, which also samples the direction bit and the substitution-table select bit. About 32 cycles later, a held done flag reports that the result is ready on the output bus.

There are two fixed substitution-table sets built in, and the choice between them is made per block. Words at the interface are byte-reversed relative to the arithmetic inside the core. Each key word has its four bytes reversed but stays in its word position. For data, the two 32-bit halves change places and each half is byte-reversed. A start that arrives while rounds are still running is dropped. The core cannot be retriggered mid-block.

Top module: `feistel64_core`

## Requirements
- R1: The key is captured on a clock edge where `key_load` is 1, and changes on `key_in` at other times have no effect. Key word i (i = 0..7) is `key_in[255-32*i -: 32]` with its bytes reversed.
- R2: On an accepted start, the right half R is `din[63:32]` and the left half L is `din[31:0]`, each byte-reversed. The result is presented as `dout = {bytes-reversed R, bytes-reversed L}`.
- R3: Every round computes the following steps:
  - s = R + subkey mod 2^32;
  - each nibble j of s (j = 0 for bits 3:0) is replaced through box j of the chosen set;
  - the result is rotated left by 11 bits and XORed into L;
  - the halves are swapped.
  The swap is omitted in round 32.
- R4: `mode_dec` is sampled with start, with 0 for encryption and 1 for decryption.
  - Encryption uses key words 0..7 three times, then 7..0.
  - Decryption uses 0..7 once, then 7..0 three times.
  - Decrypting an encrypted block restores it.
- R5: `sbox_sel` is sampled with start. A value of 0 picks the hash-standard test parameter boxes, and 1 picks the alternative commercial set.
- R6: `done` rises exactly 32 clock edges after the edge that accepts the start.
- R7: `done` and `dout` hold their values until the next accepted start. Such a start clears `done` on its accepting edge.
- R8: A start that arrives while rounds are in progress is ignored. It changes neither the result nor the completion time.
- R9: The asynchronous active-low reset clears the key store, the data state and `done`, so `dout` reads 0.
- R10: The following encrypt-then-decrypt round trip with set 0 returns the plaintext:
  - key BE5EC2006CFF9DCF52354959F1FF0CBFE95061B5A648C10387069C25997C0672, applied with the per-word byte reversal;
  - plaintext 0DF82802B741A292, applied with the half swap and byte reversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | One-cycle strobe that captures `key_in` |
| key_in | input | 256 | Key, word 0 in the top bits |
| start | input | 1 | One-cycle strobe that captures `din` and begins a block |
| mode_dec | input | 1 | 0 encrypt, 1 decrypt, sampled with start |
| sbox_sel | input | 1 | Substitution-table set, sampled with start |
| din | input | 64 | Input block |
| dout | output | 64 | Result block, valid while `done` is 1 |
| done | output | 1 | Result valid, held until the next accepted start |

## Verification
The hardest situation to reach from the ports is a start strobe that lands in the middle of a running block. It must be dropped even though it carries different data, mode and table select. The bench pulses start ten cycles into a block with a conflicting operand. It then checks that the latency is still 32 and that the result matches the first operand.

Random keys, blocks, directions and table sets are drawn from a fixed seed and compared with a bench model of the round. Directed cases cover three situations: a key bus changed without its strobe, a reset in the middle of a block, and the fixed round-trip vector.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = 2 * WORD_W;
  localparam int KEY_WORDS = 8;
  localparam int KEY_W     = KEY_WORDS * WORD_W;
  localparam int ROUNDS    = 32;
  localparam int ROUND_W   = $clog2(ROUNDS);
  localparam int KIDX_W    = $clog2(KEY_WORDS);
  localparam int NIB_W     = 4;
  localparam int NIBBLES   = WORD_W / NIB_W;
  localparam int ROT_L     = 11;
  localparam int SETS      = 2;

  typedef logic [WORD_W-1:0] word_t;

  // Entry v of each box sits at bits [4v+3:4v]; box 0 handles the lowest nibble.
  localparam logic [63:0] SBOX_TAB [SETS][NIBBLES] = '{
    '{64'h35F7C1B6_E08D29A4, 64'h95701832_AFD6C4BE, 64'hB9067CFE_243AD185,
      64'h352BC64E_F9801AD7, 64'h2B30E9A4_8DF517C6, 64'hEFC95863_D1270AB4,
      64'hC2867EA0_95F314BD, 64'hC8B6E329_4A750DF1},
    '{64'h5D0CFE4A_71B82369, 64'h1D4BC625_0FA89E73, 64'h9170A5FC_8D3B264E,
      64'h658F4B20_931DCA7E, 64'h6A7C324E_0FD8915B, 64'h6EF84957_B021CDA3,
      64'hEB3F54C8_06A792D1, 64'h4D719326_8EC05FAB}
  };

  function automatic word_t swap_bytes(word_t w);
    word_t r;
    for (int b = 0; b < WORD_W / 8; b++) begin
      r[8*b +: 8] = w[WORD_W - 8*(b+1) +: 8];
    end
    return r;
  endfunction

  function automatic logic [NIB_W-1:0] sbox_pick(logic set, int box, logic [NIB_W-1:0] v);
    return SBOX_TAB[set][box][{v, 2'b00} +: NIB_W];
  endfunction
endpackage

// File: rtl/fc_key_bank.sv
module fc_key_bank
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [KIDX_W-1:0] sel_idx,
  output word_t             subkey
);
  word_t words_q [KEY_WORDS];

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (load) begin
        words_q[g] <= swap_bytes(key_in[(KEY_WORDS-g)*WORD_W-1 -: WORD_W]);
      end
    end
  end

  assign subkey = words_q[sel_idx];
endmodule

// File: rtl/fc_key_sched.sv
module fc_key_sched
  import fc_pkg::*;
(
  input  logic [ROUND_W-1:0] round,
  input  logic               dec,
  output logic [KIDX_W-1:0]  idx
);
  localparam int PASS_W = ROUND_W - KIDX_W;

  logic [PASS_W-1:0] pass;
  logic [KIDX_W-1:0] pos;
  logic              ascending;

  always_comb begin
    pass = round[ROUND_W-1:KIDX_W];
    pos  = round[KIDX_W-1:0];
    // encryption: only the final pass descends; decryption: only the first ascends
    ascending = dec ? (pass == '0) : (pass != '1);
    idx = ascending ? pos : ~pos;
  end
endmodule

// File: rtl/fc_round_fn.sv
module fc_round_fn
  import fc_pkg::*;
(
  input  word_t right,
  input  word_t subkey,
  input  logic  set_sel,
  output word_t f_out
);
  word_t sum;
  word_t sub;

  assign sum = right + subkey;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_box
    assign sub[NIB_W*g +: NIB_W] = sbox_pick(set_sel, g, sum[NIB_W*g +: NIB_W]);
  end

  assign f_out = {sub[WORD_W-ROT_L-1:0], sub[WORD_W-1:WORD_W-ROT_L]};
endmodule

// File: rtl/feistel64_core.sv
module feistel64_core
  import fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             start,
  input  logic             mode_dec,
  input  logic             sbox_sel,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout,
  output logic             done
);
  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(ROUNDS - 1);

  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic [ROUND_W-1:0] round_q, round_d;
  logic               dec_q, dec_d;
  logic               set_q, set_d;
  word_t              n1_q, n1_d;
  word_t              n2_q, n2_d;
  logic               accept, last, state_en;
  logic [KIDX_W-1:0]  kidx;
  word_t              subkey, f_val;

  assign accept   = start & ~busy_q;
  assign last     = busy_q & (round_q == LAST_ROUND);
  assign state_en = accept | busy_q;

  fc_key_sched i_sched (
    .round (round_q),
    .dec   (dec_q),
    .idx   (kidx)
  );

  fc_key_bank i_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (key_load),
    .key_in  (key_in),
    .sel_idx (kidx),
    .subkey  (subkey)
  );

  fc_round_fn i_round (
    .right   (n1_q),
    .subkey  (subkey),
    .set_sel (set_q),
    .f_out   (f_val)
  );

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    round_d = round_q;
    dec_d   = dec_q;
    set_d   = set_q;
    n1_d    = n1_q;
    n2_d    = n2_q;
    if (accept) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      round_d = '0;
      dec_d   = mode_dec;
      set_d   = sbox_sel;
      n1_d    = swap_bytes(din[BLK_W-1:WORD_W]);
      n2_d    = swap_bytes(din[WORD_W-1:0]);
    end else if (busy_q) begin
      if (last) begin
        n2_d    = n2_q ^ f_val;
        busy_d  = 1'b0;
        done_d  = 1'b1;
        round_d = '0;
      end else begin
        n1_d    = n2_q ^ f_val;
        n2_d    = n1_q;
        round_d = round_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      round_q <= '0;
      dec_q   <= 1'b0;
      set_q   <= 1'b0;
      n1_q    <= '0;
      n2_q    <= '0;
    end else if (state_en) begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      round_q <= round_d;
      dec_q   <= dec_d;
      set_q   <= set_d;
      n1_q    <= n1_d;
      n2_q    <= n2_d;
    end
  end

  assign dout = {swap_bytes(n1_q), swap_bytes(n2_q)};
  assign done = done_q;
endmodule

// File: rtl/fc_core_checker.sv
module fc_core_checker #(
  parameter int RW = 5,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] round,
  input logic [DW-1:0] dout
);
  localparam logic [RW-1:0] LAST = '1;

  // R6: done only appears at the end of a run of rounds
  a_r6_done_after_rounds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R6: never busy and done together
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7: done held while no start arrives
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7: result bus held while done and idle
  a_r7_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(dout));

  // R7: an accepted start clears done and begins rounds
  a_r7_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  // R8: a start during rounds does not restart the counter
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && round != LAST |=> busy && (round == RW'($past(round) + 1'b1)));
endmodule

bind feistel64_core fc_core_checker #(
  .RW (fc_pkg::ROUND_W),
  .DW (fc_pkg::BLK_W)
) i_fc_core_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy_q),
  .done  (done),
  .round (round_q),
  .dout  (dout)
);

// File: tb/test_feistel64_core.sv
`timescale 1ns/1ps
module test_feistel64_core;
  logic         clk;
  logic         rst_n;
  logic         key_load;
  logic [255:0] key_in;
  logic         start;
  logic         mode_dec;
  logic         sbox_sel;
  logic [63:0]  din;
  logic [63:0]  dout;
  logic         done;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit summary_done = 0;

  feistel64_core i_feistel64_core (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .start(start), .mode_dec(mode_dec), .sbox_sel(sbox_sel),
    .din(din), .dout(dout), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] rev4(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] m_subst(logic [31:0] x, logic set);
    logic [31:0] r;
    for (int j = 0; j < 8; j++) begin
      logic [3:0] v;
      v = x[4*j +: 4];
      r[4*j +: 4] = fc_pkg::SBOX_TAB[set][j][4*v +: 4];
    end
    return r;
  endfunction

  function automatic logic [63:0] model(logic [255:0] k, logic [63:0] blk, logic dec, logic set);
    logic [31:0] kw [8];
    logic [31:0] a, b, s, f;
    int idx;
    for (int i = 0; i < 8; i++) kw[i] = rev4(k[255 - 32*i -: 32]);
    a = rev4(blk[63:32]);
    b = rev4(blk[31:0]);
    for (int r = 0; r < 32; r++) begin
      if (!dec) idx = (r < 24) ? (r % 8) : (7 - r % 8);
      else      idx = (r < 8)  ? r       : (7 - r % 8);
      s = m_subst(a + kw[idx], set);
      f = (s << 11) | (s >> 21);
      if (r < 31) begin
        logic [31:0] t;
        t = b ^ f;
        b = a;
        a = t;
      end else begin
        b = b ^ f;
      end
    end
    return {rev4(a), rev4(b)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_key(logic [255:0] k);
    @(negedge clk);
    key_load = 1'b1;
    key_in   = k;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic run_block(logic [63:0] blk, logic dec, logic set,
                           output logic [63:0] res, output int lat);
    @(negedge clk);
    start = 1'b1; din = blk; mode_dec = dec; sbox_sel = set;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    res = dout;
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    vec_cnt++;
    bad_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [255:0] key, key_ref;
    logic [63:0]  res, res2, blk, exp;
    int           lat;
    logic         d, s;
    void'($urandom(32'd2718));

    key_load = 0; key_in = '0; start = 0; mode_dec = 0; sbox_sel = 0; din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", {63'd0, done}, 64'd0);
    chk("R9 reset dout", dout, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: key store cleared by reset, zero key in use
    run_block(64'h0123456789ABCDEF, 1'b0, 1'b0, res, lat);
    chk("R9 zero key result", res, model('0, 64'h0123456789ABCDEF, 1'b0, 1'b0));

    // R10: fixed vector round trip, with interface ordering applied
    key_ref = {rev4(32'hBE5EC200), rev4(32'h6CFF9DCF), rev4(32'h52354959), rev4(32'hF1FF0CBF),
               rev4(32'hE95061B5), rev4(32'hA648C103), rev4(32'h87069C25), rev4(32'h997C0672)};
    blk = {rev4(32'hB741A292), rev4(32'h0DF82802)};
    load_key(key_ref);
    run_block(blk, 1'b0, 1'b0, res, lat);
    chk("R3 fixed vector encrypt", res, model(key_ref, blk, 1'b0, 1'b0));
    chk("R6 latency", 64'(lat), 64'd32);
    run_block(res, 1'b1, 1'b0, res2, lat);
    chk("R10 round trip", res2, blk);

    // R7: done and dout held while idle
    repeat (6) @(negedge clk);
    chk("R7 done held", {63'd0, done}, 64'd1);
    chk("R7 dout held", dout, res2);

    // R7: accepted start clears done on its edge
    @(negedge clk);
    start = 1'b1; din = blk; mode_dec = 0; sbox_sel = 1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done cleared", {63'd0, done}, 64'd0);
    lat = 0;
    while (!done && lat < 64) begin @(negedge clk); lat++; end
    chk("R5 alternate set", dout, model(key_ref, blk, 1'b0, 1'b1));
    chk("R6 latency alt", 64'(lat), 64'd32);

    // R1: key bus changes without the strobe are ignored
    key_in = ~key_ref;
    run_block(blk, 1'b0, 1'b0, res, lat);
    chk("R1 key without strobe", res, model(key_ref, blk, 1'b0, 1'b0));

    // R8: conflicting start in the middle of a block
    @(negedge clk);
    start = 1'b1; din = blk; mode_dec = 0; sbox_sel = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (10) begin @(negedge clk); lat++; end
    start = 1'b1; din = ~blk; mode_dec = 1; sbox_sel = 1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 64) begin @(negedge clk); lat++; end
    chk("R8 ignored start result", dout, model(key_ref, blk, 1'b0, 1'b0));
    chk("R8 ignored start latency", 64'(lat), 64'd32);

    // R9: reset in the middle of a block
    @(negedge clk);
    start = 1'b1; din = blk; mode_dec = 0; sbox_sel = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid reset done", {63'd0, done}, 64'd0);
    chk("R9 mid reset dout", dout, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3/R4/R5: random keys, blocks, directions, tables
    key = key_ref;
    for (int n = 0; n < 48; n++) begin
      if (n % 8 == 0) begin
        for (int w = 0; w < 8; w++) key[32*w +: 32] = $urandom;
        load_key(key);
      end
      blk = {$urandom, $urandom};
      d = 1'($urandom);
      s = 1'($urandom);
      exp = model(key, blk, d, s);
      run_block(blk, d, s, res, lat);
      chk(d ? "R4 random decrypt" : "R3 random encrypt", res, exp);
      if (n % 4 == 0) begin
        run_block(res, ~d, s, res2, lat);
        chk("R4 inverse direction", res2, blk);
      end
    end

    // R2: half ordering, single-bit input patterns
    for (int b = 0; b < 64; b += 21) begin
      blk = 64'd1 << b;
      run_block(blk, 1'b0, 1'b1, res, lat);
      chk("R2 ordering", res, model(key, blk, 1'b0, 1'b1));
    end

    finish_up();
  end
endmodule